// File: doc/BRIEF.md
# Bit-Parallel Three-Valued Fault Lane Evaluator

This block evaluates a single logic gate for many copies of a circuit at the same time, as one step of parallel stuck-at fault simulation. A signal is a word of lanes. Lane 0 carries the fault-free circuit, and each higher lane carries a copy of the circuit with one fault injected. Each lane holds a three-valued logic value (0, 1 or unknown X) in a two-bit code. This code is chosen so that plain bitwise AND and OR on the whole word give the correct three-valued result in every lane at once. The other gate functions are built from short chains of bitwise operations.

A sequencer outside the block walks the netlist in level order. For each gate it presents the operand words and the gate type, together with two per-lane masks that force the gate output low or high in the lanes whose fault sits on this node. One cycle later the block returns the result word and a per-lane flag. The flag is set for each faulty lane whose known value disagrees with the known value of the good lane. At a primary output this flag marks the lanes whose fault the current pattern detects.

Top module: `fault_lane_eval`

## Requirements
- R1: Lane i sits at bits [2i+1:2i] of every operand and result word, with the upper bit first. The codes are 0 = `00`, 1 = `11` and X = `10`. The result word never holds the code `01`.
- R2: An operand lane that holds the unused code `01` is taken as X.
- R3: The gate select `gate_sel` chooses the function: 0 AND, 1 OR, 2 NAND, 3 NOR. These follow three-valued rules. A 0 on either input of AND or NAND controls the output even when the other input is X, and so does a 1 on either input of OR or NOR. When neither input controls the output and an input is X, the result is X.
- R4: Select 4 is XOR and select 5 is XNOR. Their result is X in any lane where either input is X. Otherwise it is the parity of the inputs, inverted for XNOR.
- R5: Select 6 is NOT of operand a and select 7 is BUF of operand a. NOT of X is X. For these two selects operand b has no effect on any output.
- R6: The force masks act on the gate result after evaluation. A set bit in `force_hi` makes that lane `11`. A set bit in `force_lo` makes that lane `00`. When both bits are set for a lane, the `force_hi` bit wins.
- R7: Bit i of `detect` (i ≥ 1) is set only when result lane i and result lane 0 both hold known values that differ. A lane holding X is never flagged, and bit 0 is always 0.
- R8: `out_valid` is `in_valid` delayed by one clock. `result` and `detect` load only on a cycle with `in_valid` high and hold their values otherwise.
- R9: While `rst_n` is low, `out_valid`, `result` and `detect` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands on this cycle are to be evaluated |
| gate_sel | input | 3 | Gate function select |
| a_word | input | 2*LANES | First operand word, two bits per lane |
| b_word | input | 2*LANES | Second operand word, two bits per lane |
| force_lo | input | LANES | Per-lane force-to-0 mask |
| force_hi | input | LANES | Per-lane force-to-1 mask |
| out_valid | output | 1 | Result and detect hold a new evaluation |
| result | output | 2*LANES | Registered result word |
| detect | output | LANES | Registered per-lane disagreement flags |

## Verification
The bench covers all eight gate functions with pseudo-random lane codes that include X and the unused `01` code, and compares each result against a three-valued model. A design that treated X as a plain bit pattern in XOR would return 0 or 1 where X belongs. A design that passed `01` through would produce illegal codes. Directed cases cover the following: a controlling 0 against X, where a wrong design gives X instead of 0; both force bits set, where reversed priority gives `00`; X lanes that differ from the good lane, which must not be flagged; and a changed operand b under NOT, which a design that read b would let leak into the result. The bench also checks that the outputs hold while `in_valid` is low.

// File: rtl/fpe_pkg.sv
package fpe_pkg;

   typedef enum logic [2:0] {
      G_AND  = 3'd0,
      G_OR   = 3'd1,
      G_NAND = 3'd2,
      G_NOR  = 3'd3,
      G_XOR  = 3'd4,
      G_XNOR = 3'd5,
      G_NOT  = 3'd6,
      G_BUF  = 3'd7
   } gate_e;

   localparam logic [1:0] CODE_ZERO = 2'b00;
   localparam logic [1:0] CODE_ONE  = 2'b11;
   localparam logic [1:0] CODE_UNK  = 2'b10;

endpackage

// File: rtl/fpe_normalize.sv
module fpe_normalize #(
   parameter int LANES = 32,
   localparam int W = 2 * LANES
) (
   input  logic [W-1:0] raw,
   output logic [W-1:0] clean
);
   // Maps the unused code 01 onto X (10); legal codes pass unchanged.
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign clean[2*i+1] = raw[2*i+1] | raw[2*i];
      assign clean[2*i]   = raw[2*i+1] & raw[2*i];
   end
endmodule

// File: rtl/fpe_gate_core.sv
module fpe_gate_core
   import fpe_pkg::*;
#(
   parameter int LANES = 32,
   localparam int W = 2 * LANES
) (
   input  gate_e        sel,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] y
);
   logic [LANES-1:0] ah, al, bh, bl, yh, yl;
   logic [LANES-1:0] and_h, and_l, or_h, or_l;
   logic [LANES-1:0] unk, par, xor_h, xor_l;

   for (genvar i = 0; i < LANES; i++) begin : g_split
      assign ah[i] = a[2*i+1];
      assign al[i] = a[2*i];
      assign bh[i] = b[2*i+1];
      assign bl[i] = b[2*i];
      assign y[2*i+1] = yh[i];
      assign y[2*i]   = yl[i];
   end

   // AND/OR on both planes are exact under the 00/11/10 code.
   assign and_h = ah & bh;
   assign and_l = al & bl;
   assign or_h  = ah | bh;
   assign or_l  = al | bl;

   // XOR: unknown if either lane is X, else parity of the low planes.
   assign unk   = (ah & ~al) | (bh & ~bl);
   assign par   = al ^ bl;
   assign xor_h = unk | par;
   assign xor_l = ~unk & par;

   // Inversion swaps and complements the planes, keeping X as 10.
   always_comb begin
      unique case (sel)
         G_AND:  begin yh = and_h;  yl = and_l;  end
         G_OR:   begin yh = or_h;   yl = or_l;   end
         G_NAND: begin yh = ~and_l; yl = ~and_h; end
         G_NOR:  begin yh = ~or_l;  yl = ~or_h;  end
         G_XOR:  begin yh = xor_h;  yl = xor_l;  end
         G_XNOR: begin yh = ~xor_l; yl = ~xor_h; end
         G_NOT:  begin yh = ~al;    yl = ~ah;    end
         default: begin yh = ah;    yl = al;     end
      endcase
   end
endmodule

// File: rtl/fpe_force.sv
module fpe_force #(
   parameter int LANES = 32,
   localparam int W = 2 * LANES
) (
   input  logic [W-1:0]     y_in,
   input  logic [LANES-1:0] lo_mask,
   input  logic [LANES-1:0] hi_mask,
   output logic [W-1:0]     y_out
);
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      always_comb begin
         if (hi_mask[i])      y_out[2*i+1 -: 2] = 2'b11;
         else if (lo_mask[i]) y_out[2*i+1 -: 2] = 2'b00;
         else                 y_out[2*i+1 -: 2] = y_in[2*i+1 -: 2];
      end
   end
endmodule

// File: rtl/fpe_detect.sv
module fpe_detect #(
   parameter int LANES = 32,
   localparam int W = 2 * LANES
) (
   input  logic [W-1:0]     y,
   output logic [LANES-1:0] flag
);
   logic good_known;
   assign good_known = (y[1] == y[0]);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      if (i == 0) begin : g_ref
         assign flag[i] = 1'b0;
      end else begin : g_cmp
         assign flag[i] = good_known && (y[2*i+1] == y[2*i]) && (y[2*i] != y[0]);
      end
   end
endmodule

// File: rtl/fault_lane_eval.sv
module fault_lane_eval
   import fpe_pkg::*;
#(
   parameter int LANES = 32,
   localparam int W = 2 * LANES
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [2:0]       gate_sel,
   input  logic [W-1:0]     a_word,
   input  logic [W-1:0]     b_word,
   input  logic [LANES-1:0] force_lo,
   input  logic [LANES-1:0] force_hi,
   output logic             out_valid,
   output logic [W-1:0]     result,
   output logic [LANES-1:0] detect
);
   if (LANES < 2 || LANES > 64) begin : g_bad_lanes
      $error("fault_lane_eval: LANES must lie in 2..64");
   end

   logic [W-1:0]     a_n, b_n, y_raw, y_forced;
   logic [LANES-1:0] det_c;

   fpe_normalize #(.LANES(LANES)) u_norm_a (.raw(a_word), .clean(a_n));
   fpe_normalize #(.LANES(LANES)) u_norm_b (.raw(b_word), .clean(b_n));

   fpe_gate_core #(.LANES(LANES)) u_core (
      .sel(gate_e'(gate_sel)), .a(a_n), .b(b_n), .y(y_raw));

   fpe_force #(.LANES(LANES)) u_force (
      .y_in(y_raw), .lo_mask(force_lo), .hi_mask(force_hi), .y_out(y_forced));

   fpe_detect #(.LANES(LANES)) u_det (.y(y_forced), .flag(det_c));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
         detect    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result <= y_forced;
            detect <= det_c;
         end
      end
   end

   p_valid_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_valid_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(result) && $stable(detect)));
   p_ref_lane_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !detect[0]);

   for (genvar i = 0; i < LANES; i++) begin : g_chk
      p_legal_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
         result[2*i+1 -: 2] != 2'b01);
      p_hi_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && force_hi[i]) |=> (result[2*i+1 -: 2] == 2'b11));
      p_unk_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (result[2*i+1 -: 2] == 2'b10) |-> !detect[i]);
   end
endmodule

// File: tb/sim_fault_lane_eval.sv
module sim_fault_lane_eval;
   localparam int L = 4;
   localparam int W = 2 * L;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [2:0] gate_sel = '0;
   logic [W-1:0] a_word = '0, b_word = '0;
   logic [L-1:0] force_lo = '0, force_hi = '0;
   logic out_valid;
   logic [W-1:0] result;
   logic [L-1:0] detect;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   fault_lane_eval #(.LANES(L)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .gate_sel(gate_sel),
      .a_word(a_word), .b_word(b_word), .force_lo(force_lo), .force_hi(force_hi),
      .out_valid(out_valid), .result(result), .detect(detect));

   function automatic int dec(logic [1:0] c);
      if (c == 2'b00) return 0;
      if (c == 2'b11) return 1;
      return 2;
   endfunction

   function automatic logic [1:0] enc(int v);
      if (v == 0) return 2'b00;
      if (v == 1) return 2'b11;
      return 2'b10;
   endfunction

   function automatic int inv(int v);
      return (v == 2) ? 2 : 1 - v;
   endfunction

   function automatic int ev(int g, int x, int y);
      int t;
      case (g)
         0, 2: begin
            if (x == 0 || y == 0) t = 0;
            else if (x == 1 && y == 1) t = 1;
            else t = 2;
            return (g == 2) ? inv(t) : t;
         end
         1, 3: begin
            if (x == 1 || y == 1) t = 1;
            else if (x == 0 && y == 0) t = 0;
            else t = 2;
            return (g == 3) ? inv(t) : t;
         end
         4, 5: begin
            t = (x == 2 || y == 2) ? 2 : (x ^ y);
            return (g == 5) ? inv(t) : t;
         end
         6: return inv(x);
         default: return x;
      endcase
   endfunction

   task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   logic [W-1:0] last_res;
   logic [L-1:0] last_det;

   task automatic apply(logic [W-1:0] a, logic [W-1:0] b, int g,
                        logic [L-1:0] lo, logic [L-1:0] hi, string tag);
      logic [W-1:0] er;
      logic [L-1:0] ed;
      int e [L];
      @(negedge clk);
      a_word = a; b_word = b; gate_sel = 3'(g);
      force_lo = lo; force_hi = hi; in_valid = 1'b1;
      for (int i = 0; i < L; i++) begin
         e[i] = ev(g, dec(a[2*i+1 -: 2]), dec(b[2*i+1 -: 2]));
         if (hi[i]) e[i] = 1;
         else if (lo[i]) e[i] = 0;
         er[2*i+1 -: 2] = enc(e[i]);
      end
      for (int i = 0; i < L; i++)
         ed[i] = (i > 0) && e[i] != 2 && e[0] != 2 && e[i] != e[0];
      @(negedge clk);
      in_valid = 1'b0;
      check(out_valid == 1'b1, "R8 out_valid", 64'(out_valid), 64'd1);
      check(result == er, {tag, " result"}, 64'(result), 64'(er));
      check(detect == ed, "R7 detect", 64'(detect), 64'(ed));
      last_res = er;
      last_det = ed;
   endtask

   initial begin
      logic [31:0] r;
      string tg;
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R9 out_valid", 64'(out_valid), 64'd0);
      check(result == '0, "R9 result", 64'(result), 64'd0);
      check(detect == '0, "R9 detect", 64'(detect), 64'd0);
      rst_n = 1'b1;

      // R3: controlling 0 against X, no-control X
      apply(8'b10_10_00_10, 8'b00_11_11_00, 0, '0, '0, "R3 and ctrl");
      apply(8'b10_00_00_11, 8'b11_10_00_10, 1, '0, '0, "R3 or");
      // R2: code 01 is X: 01 AND 11 -> X, 01 OR 00 -> X
      apply(8'b01_01_01_01, 8'b11_11_11_11, 0, '0, '0, "R2 and");
      apply(8'b01_01_11_00, 8'b00_00_00_00, 1, '0, '0, "R2 or");
      // R4: X in xor
      apply(8'b10_11_00_11, 8'b11_10_11_11, 4, '0, '0, "R4 xor");
      // R5: NOT with two different b words, same result
      apply(8'b10_11_00_11, 8'b00_00_00_00, 6, '0, '0, "R5 not b0");
      apply(8'b10_11_00_11, 8'b11_10_01_11, 6, '0, '0, "R5 not b1");
      apply(8'b10_11_00_11, 8'b01_10_11_00, 7, '0, '0, "R5 buf");
      // R6: both masks set -> high wins; force after NAND
      apply(8'b11_11_11_11, 8'b11_11_11_11, 2, 4'b1110, 4'b1010, "R6 prio");
      // R7: X lanes differ from good lane but are not flagged
      apply(8'b10_00_10_11, 8'b00_00_00_00, 7, '0, '0, "R7 xlane");
      apply(8'b11_00_11_10, 8'b00_00_00_00, 7, '0, '0, "R7 goodx");

      // R8: operands change with in_valid low; outputs hold
      @(negedge clk);
      a_word = ~a_word; gate_sel = 3'd6; force_hi = '1;
      @(negedge clk);
      check(out_valid == 1'b0, "R8 idle valid", 64'(out_valid), 64'd0);
      check(result == last_res, "R8 hold result", 64'(result), 64'(last_res));
      check(detect == last_det, "R8 hold detect", 64'(detect), 64'(last_det));

      // Sweep of every gate over pseudo-random lane codes (R1 R3 R4 R5 R6 R7)
      r = 32'h1d2c_3b4a;
      for (int g = 0; g < 8; g++) begin
         tg = (g < 4) ? "R3 sweep" : (g < 6) ? "R4 sweep" : "R5 sweep";
         for (int n = 0; n < 300; n++) begin
            r = {r[30:0], r[31] ^ r[21] ^ r[1] ^ r[0]};
            r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
            apply(r[7:0], r[15:8], g, r[19:16] & r[23:20],
                  r[27:24] & r[31:28] & r[3:0], {tg, " R1 R6"});
         end
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule